// File: doc/BRIEF.md
# Register-Access Wake and Auto-Powerdown Controller

This block governs the low-power state of a disk-drive style peripheral controller attached to a byte-wide host register bus. It decodes every host read and write at the eight register offsets. Each access is classed by register and by direction into one of two kinds. Some accesses are served quietly while the core sleeps. Others wake the core and restart its idle timer.

The host can also force a wake in two ways: by pulsing hardware reset, or by setting a soft-reset bit in one of two writable registers. A soft reset emits a one-cycle reset request to the core and clears the register file.

While the core is awake, an idle counter runs for as long as three conditions hold: every motor-enable bit is clear, no command is in progress, and the FIFO is empty. When the counter reaches its programmed length, the block drops the core back into powerdown and turns off the drive-side output enable. The register file stays live the whole time, so values written during powerdown are kept and read back correctly after a wake.

Top module: `pdw_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the cycle it is released, the block is awake. In that state `powered_down`=0, `drive_oe`=1, `wake_pulse`=0, `core_rst`=0, and `ctrl_reg`, `rate_reg` and `cfg_reg` are all zero. This holds even if the block was powered down before reset.
- R2: A soft reset requested by a write to offset 2 with bit 2 set, or by a write to offset 4 with bit 7 set, has the following effect one cycle later: the block is awake, `core_rst` is high for that single cycle, and all three registers read zero.
- R3: A write to offset 2 with any of bits 7:4 (motor enables) set wakes the block. A write to offset 2 with bits 7:4 and bit 2 clear does not wake it, and its value is stored. A read of offset 2 never wakes the block.
- R4: A read of offset 4 (engine status) wakes the block. A read or a write of offset 5 (data port) also wakes it. These wakes leave the three registers unchanged.
- R5: Once awake, the block sets `powered_down` after PD_CYCLES consecutive idle cycles. An idle cycle is one with `ctrl_reg[7:4]`=0, `cmd_busy`=0 and `fifo_empty`=1. A single non-idle cycle restarts the count from zero.
- R6: Every waking access restarts the idle count, whether the block was powered down or already awake. `powered_down` then rises PD_CYCLES clock edges after the edge that took the access, provided every cycle in between was idle.
- R7: Accesses that do not wake leave `powered_down` set. These are reads of offsets 0, 1, 2, 3, 6 and 7, writes to offset 2 without motor or reset bits, writes to offset 4 without bit 7, and writes to offset 7. Writes among them update `ctrl_reg` (offset 2), `rate_reg` (offset 4) or `cfg_reg` (offset 7).
- R8: `wake_pulse` is high for exactly one cycle, on the cycle after an edge that moves the block from powered down to awake. It stays low for a waking access made while the block is already awake.
- R9: `drive_oe` is low exactly while `powered_down` is high.
- R10: When `bus_rd` is high, `bus_rdata` returns the following. Offset 0 gives `status_lo_i`, 1 gives `status_hi_i`, 2 gives `ctrl_reg`, 4 gives `engine_stat_i`, 5 gives `fifo_data_i`, 7 gives `line_stat_i`, and offsets 3 and 6 give zero. It returns the same values in powerdown. With `bus_rd` low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low |
| bus_addr | input | 3 | Register offset of the host access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| status_lo_i | input | 8 | Live status byte served at offset 0 |
| status_hi_i | input | 8 | Live status byte served at offset 1 |
| engine_stat_i | input | 8 | Command engine status served at offset 4 |
| fifo_data_i | input | 8 | FIFO head byte served at offset 5 |
| line_stat_i | input | 8 | Drive line status served at offset 7 |
| cmd_busy | input | 1 | A command is in progress |
| fifo_empty | input | 1 | The data FIFO holds nothing |
| powered_down | output | 1 | Core is in powerdown |
| wake_pulse | output | 1 | One-cycle pulse on leaving powerdown |
| core_rst | output | 1 | One-cycle soft reset request to the core |
| drive_oe | output | 1 | Drive-interface output enable |
| ctrl_reg | output | 8 | Drive control register (offset 2) |
| rate_reg | output | 8 | Rate select register (offset 4 write) |
| cfg_reg | output | 8 | Configuration register (offset 7 write) |

## Verification
The classifier is walked while the block sleeps with a table that visits every offset in both directions. The table includes offset-2 writes with and without motor or reset bits, and offset-4 writes with and without bit 7, so every quiet access is set against its waking neighbour at the same offset. Timing patterns are used to tell apart the count that begins on a wake from the count that restarts after a busy or non-empty cycle mid-way, and both are sampled one cycle before and at the exact entry edge. A motor-on idle run shows that the motor bits alone hold the core awake. A hardware reset taken in powerdown separates the two reset paths.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    typedef enum logic [2:0] {
        OFS_ST_LO   = 3'd0,
        OFS_ST_HI   = 3'd1,
        OFS_CTRL    = 3'd2,
        OFS_RSV3    = 3'd3,
        OFS_RATE    = 3'd4,
        OFS_DATA    = 3'd5,
        OFS_RSV6    = 3'd6,
        OFS_LINECFG = 3'd7
    } ofs_e;

    localparam int CTRL_SRST_BIT = 2;
    localparam int RATE_SRST_BIT = 7;
    localparam int MOTOR_LSB     = 4;
    localparam int MOTOR_W       = 4;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] rate;
        logic [7:0] cfg;
    } regs_t;

endpackage

// File: rtl/pdw_decode.sv
module pdw_decode
    import pdw_pkg::*;
(
    input  logic [2:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [MOTOR_W-1:0] wr_motor_bits,
    input  logic               wr_ctrl_srst,
    input  logic               wr_rate_srst,
    output logic               wr_ctrl,
    output logic               wr_rate,
    output logic               wr_cfg,
    output logic               acc_wake,
    output logic               soft_rst
);

    ofs_e ofs;

    always_comb begin
        ofs      = ofs_e'(bus_addr);
        wr_ctrl  = bus_wr && (ofs == OFS_CTRL);
        wr_rate  = bus_wr && (ofs == OFS_RATE);
        wr_cfg   = bus_wr && (ofs == OFS_LINECFG);
        soft_rst = (wr_ctrl && wr_ctrl_srst) || (wr_rate && wr_rate_srst);
        // R3 / R4: per-register, per-direction wake classification
        acc_wake = (wr_ctrl && (|wr_motor_bits))
                || (bus_rd && (ofs == OFS_RATE))
                || ((bus_rd || bus_wr) && (ofs == OFS_DATA));
    end

endmodule

// File: rtl/pdw_regfile.sv
module pdw_regfile
    import pdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    input  logic       wr_ctrl,
    input  logic       wr_rate,
    input  logic       wr_cfg,
    input  logic       soft_rst,
    input  logic [7:0] status_lo_i,
    input  logic [7:0] status_hi_i,
    input  logic [7:0] engine_stat_i,
    input  logic [7:0] fifo_data_i,
    input  logic [7:0] line_stat_i,
    output logic [7:0] ctrl_q,
    output logic [7:0] rate_q,
    output logic [7:0] cfg_q,
    output logic [7:0] rdata
);

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (soft_rst) begin
            r_d = '0;
        end else begin
            if (wr_ctrl) r_d.ctrl = bus_wdata;
            if (wr_rate) r_d.rate = bus_wdata;
            if (wr_cfg)  r_d.cfg  = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            case (ofs_e'(bus_addr))
                OFS_ST_LO:   rdata = status_lo_i;
                OFS_ST_HI:   rdata = status_hi_i;
                OFS_CTRL:    rdata = r_q.ctrl;
                OFS_RATE:    rdata = engine_stat_i;
                OFS_DATA:    rdata = fifo_data_i;
                OFS_LINECFG: rdata = line_stat_i;
                default:     rdata = '0;
            endcase
        end
    end

    assign ctrl_q = r_q.ctrl;
    assign rate_q = r_q.rate;
    assign cfg_q  = r_q.cfg;

    assert_srst_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (r_q == '0));

    assert_quiet_write_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !soft_rst) |=> (r_q.cfg == $past(bus_wdata)));

endmodule

// File: rtl/pdw_idle_timer.sv
module pdw_idle_timer #(
    parameter int PD_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic acc_wake,
    input  logic soft_rst,
    output logic pd_q_o,
    output logic wake_q_o,
    output logic crst_q_o
);

    localparam int CW = (PD_CYCLES > 1) ? $clog2(PD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PD_CYCLES - 1);

    typedef struct packed {
        logic          pd;
        logic [CW-1:0] cnt;
        logic          wake;
        logic          crst;
    } tmr_t;

    tmr_t t_d, t_q;
    logic wake_evt;

    always_comb begin
        wake_evt = acc_wake || soft_rst;
        t_d      = t_q;
        t_d.wake = 1'b0;
        t_d.crst = 1'b0;
        if (wake_evt) begin
            t_d.pd   = 1'b0;
            t_d.cnt  = '0;
            t_d.wake = t_q.pd;
            t_d.crst = soft_rst;
        end else if (t_q.pd) begin
            t_d.cnt = '0;
        end else if (!idle) begin
            t_d.cnt = '0;
        end else if (t_q.cnt == LAST) begin
            t_d.pd  = 1'b1;
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pd_q_o   = t_q.pd;
    assign wake_q_o = t_q.wake;
    assign crst_q_o = t_q.crst;

    assert_pd_entry_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.pd) |-> $past(idle && !wake_evt));

    assert_wake_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (!t_q.pd && t_q.cnt == '0));

    assert_sleep_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.pd && !wake_evt) |=> t_q.pd);

    assert_wake_pulse_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.wake |-> $fell(t_q.pd));

    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LAST);

endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
    import pdw_pkg::*;
#(
    parameter int PD_CYCLES = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] status_lo_i,
    input  logic [7:0] status_hi_i,
    input  logic [7:0] engine_stat_i,
    input  logic [7:0] fifo_data_i,
    input  logic [7:0] line_stat_i,
    input  logic       cmd_busy,
    input  logic       fifo_empty,
    output logic       powered_down,
    output logic       wake_pulse,
    output logic       core_rst,
    output logic       drive_oe,
    output logic [7:0] ctrl_reg,
    output logic [7:0] rate_reg,
    output logic [7:0] cfg_reg
);

    logic wr_ctrl, wr_rate, wr_cfg, acc_wake, soft_rst;
    logic idle, pd_q;

    pdw_decode u_dec (
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .wr_motor_bits (bus_wdata[MOTOR_LSB +: MOTOR_W]),
        .wr_ctrl_srst  (bus_wdata[CTRL_SRST_BIT]),
        .wr_rate_srst  (bus_wdata[RATE_SRST_BIT]),
        .wr_ctrl       (wr_ctrl),
        .wr_rate       (wr_rate),
        .wr_cfg        (wr_cfg),
        .acc_wake      (acc_wake),
        .soft_rst      (soft_rst)
    );

    pdw_regfile u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .wr_ctrl       (wr_ctrl),
        .wr_rate       (wr_rate),
        .wr_cfg        (wr_cfg),
        .soft_rst      (soft_rst),
        .status_lo_i   (status_lo_i),
        .status_hi_i   (status_hi_i),
        .engine_stat_i (engine_stat_i),
        .fifo_data_i   (fifo_data_i),
        .line_stat_i   (line_stat_i),
        .ctrl_q        (ctrl_reg),
        .rate_q        (rate_reg),
        .cfg_q         (cfg_reg),
        .rdata         (bus_rdata)
    );

    always_comb begin
        idle = (ctrl_reg[MOTOR_LSB +: MOTOR_W] == '0) && !cmd_busy && fifo_empty;
    end

    pdw_idle_timer #(.PD_CYCLES(PD_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .acc_wake (acc_wake),
        .soft_rst (soft_rst),
        .pd_q_o   (pd_q),
        .wake_q_o (wake_pulse),
        .crst_q_o (core_rst)
    );

    assign powered_down = pd_q;
    assign drive_oe     = !pd_q;

    assert_motor_holds_awake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[MOTOR_LSB +: MOTOR_W] != '0 && !powered_down) |=> !powered_down);

endmodule

// File: tb/tb_pdw_ctrl.sv
module tb_pdw_ctrl;

    localparam int PD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] st_lo = 8'hA1, st_hi = 8'hB2, eng = 8'h4C, fdat = 8'h5D, line = 8'h7E;
    logic       cmd_busy = 1'b0, fifo_empty = 1'b1;
    logic       powered_down, wake_pulse, core_rst, drive_oe;
    logic [7:0] ctrl_reg, rate_reg, cfg_reg;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] last_rd;

    always #5 clk = ~clk;

    pdw_ctrl #(.PD_CYCLES(PD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_lo_i(st_lo),
        .status_hi_i(st_hi), .engine_stat_i(eng), .fifo_data_i(fdat), .line_stat_i(line),
        .cmd_busy(cmd_busy), .fifo_empty(fifo_empty), .powered_down(powered_down),
        .wake_pulse(wake_pulse), .core_rst(core_rst), .drive_oe(drive_oe),
        .ctrl_reg(ctrl_reg), .rate_reg(rate_reg), .cfg_reg(cfg_reg)
    );

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [2:0] addr;
        logic [7:0] wd;
        logic [7:0] exp_rd;
        logic       exp_pd;
        logic       exp_crst;
    } vec_t;

    localparam vec_t VECS [0:15] = '{
        '{1'b1, 1'b0, 3'd0, 8'h00, 8'hA1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd1, 8'h00, 8'hB2, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd2, 8'h00, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd2, 8'h03, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd2, 8'h00, 8'h03, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd4, 8'h05, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd7, 8'h02, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd7, 8'h00, 8'h7E, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd3, 8'h00, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd6, 8'h00, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd4, 8'h00, 8'h4C, 1'b0, 1'b0},
        '{1'b1, 1'b0, 3'd5, 8'h00, 8'h5D, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'd5, 8'h99, 8'h00, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'd2, 8'h10, 8'h00, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'd2, 8'h04, 8'h00, 1'b0, 1'b1},
        '{1'b0, 1'b1, 3'd4, 8'h80, 8'h00, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic r, input logic w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1 last_rd = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic go_sleep();
        if (!powered_down) begin
            acc(1'b0, 1'b1, 3'd2, 8'h00);
            repeat (PD + 2) @(negedge clk);
        end
    endtask

    task automatic idle_break(input bit use_busy, input string req);
        acc(1'b1, 1'b0, 3'd4, 8'h00);          // wake, now at n1
        repeat (4) @(negedge clk);             // n5
        if (use_busy) cmd_busy = 1'b1; else fifo_empty = 1'b0;
        @(negedge clk);                        // n6
        cmd_busy = 1'b0; fifo_empty = 1'b1;
        repeat (PD - 1) @(negedge clk);
        chk({req, " before restart expiry"}, powered_down, 1'b0);
        @(negedge clk);
        chk({req, " at restart expiry"}, powered_down, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pd in reset", powered_down, 1'b0);
        chk("R1 oe in reset", drive_oe, 1'b1);
        chk("R1 regs in reset", {ctrl_reg, rate_reg, cfg_reg}, 24'h0);
        chk("R1 wake in reset", wake_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 awake after release", powered_down, 1'b0);

        // R6 / R8: waking access while awake restarts count, no pulse
        repeat (5) @(negedge clk);
        acc(1'b1, 1'b0, 3'd5, 8'h00);
        chk("R8 no pulse when awake", wake_pulse, 1'b0);
        repeat (PD - 1) @(negedge clk);
        chk("R6 awake one before expiry", powered_down, 1'b0);
        @(negedge clk);
        chk("R6 sleeps at expiry", powered_down, 1'b1);
        chk("R9 oe off in sleep", drive_oe, 1'b0);

        // R10: no read -> zero
        bus_addr = 3'd0;
        #1 chk("R10 rdata idle", bus_rdata, 8'h00);

        // table walk
        for (int i = 0; i < 16; i++) begin
            go_sleep();
            acc(VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].wd);
            if (VECS[i].rd) chk("R10 read map", last_rd, VECS[i].exp_rd);
            chk("R3/R4/R7 wake class", powered_down, VECS[i].exp_pd);
            chk("R8 wake pulse", wake_pulse, !VECS[i].exp_pd);
            chk("R9 drive oe", drive_oe, !VECS[i].exp_pd);
            chk("R2 core reset pulse", core_rst, VECS[i].exp_crst);
            if (i == 9)
                chk("R7 kept writes", {ctrl_reg, rate_reg, cfg_reg}, 24'h030502);
            if (i == 10) begin
                chk("R4 state intact", {ctrl_reg, rate_reg, cfg_reg}, 24'h030502);
                @(negedge clk);
                chk("R8 pulse one cycle", wake_pulse, 1'b0);
            end
            if (i == 14 || i == 15) begin
                chk("R2 regs cleared", {ctrl_reg, rate_reg, cfg_reg}, 24'h0);
                @(negedge clk);
                chk("R2 reset pulse one cycle", core_rst, 1'b0);
            end
        end

        // R5: non-idle cycle restarts count
        go_sleep();
        idle_break(1'b1, "R5 busy");
        idle_break(1'b0, "R5 fifo");

        // R5: motor bit keeps awake
        acc(1'b0, 1'b1, 3'd2, 8'h20);
        repeat (PD + 4) @(negedge clk);
        chk("R5 motor on stays awake", powered_down, 1'b0);
        go_sleep();
        chk("R5 motor off sleeps", powered_down, 1'b1);

        // R1: hardware reset from powerdown
        acc(1'b0, 1'b1, 3'd7, 8'h55);
        chk("R7 cfg write in sleep", cfg_reg, 8'h55);
        rst_n = 1'b0;
        #1;
        chk("R1 hw reset wakes", powered_down, 1'b0);
        chk("R1 hw reset clears", cfg_reg, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule